// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Interface

This block is the digital front end of an 8-bit serial-input converter. A host sends each code over three wires: a serial clock, a serial data line and an active-low frame strobe that also acts as chip enable. The block shifts the bits into an 8-bit shift register. When a full frame closes, it places the word in an input latch. A separate active-low load strobe moves the latched word into the DAC register, whose value is the block's main output.

All four pins are brought into the system clock domain through two flip-flop stages, and every edge is detected in that domain. A frame only begins on a fresh falling edge of the frame strobe. A frame that closes early is thrown away. Clock edges beyond the eighth bit are ignored. An interface-enable output follows the frame strobe and models powering the serial input buffers up and down. A one-cycle completion pulse marks each accepted word. If the load strobe is held low, every completed word reaches the DAC register on its own.

Top module: `sdac_front`

## Requirements
- R1: A word is 8 bits sent most significant bit first. After a full frame carrying bits b7..b0 in that order is loaded, `dac_code_o[7]` equals b7 and `dac_code_o[0]` equals b0.
- R2: A data bit is taken only on a falling edge of `ser_clk_i`. Rising edges never shift the register.
- R3: While `frm_n_i` is high, `ser_clk_i` and `ser_dat_i` activity has no effect. No pulse is raised, and both the input latch and the DAC register keep their values.
- R4: A frame starts only on a falling edge of `frm_n_i`, and that edge restarts the bit count. The word of a frame that follows an aborted one holds only the bits of the new frame.
- R5: When `load_n_i` is high, a completed word waits in the input latch and `dac_code_o` is unchanged. A later low level on `load_n_i` copies it into the DAC register. With no word waiting, a low level on `load_n_i` leaves `dac_code_o` unchanged.
- R6: When `load_n_i` is held low, `dac_code_o` takes the new word one system clock after `frame_done_o` pulses.
- R7: If `frm_n_i` rises after fewer than 8 falling clock edges, the frame is discarded. No pulse is raised, and the input latch and the DAC register keep their previous contents.
- R8: Falling clock edges after the eighth within one frame are ignored, so the first 8 bits are kept.
- R9: `frame_done_o` is high for exactly one system clock after `frm_n_i` rises on a frame that received at least 8 bits.
- R10: `if_en_o` rises three system clocks after `frm_n_i` falls and falls three system clocks after it rises. The third clock is the one at which the synchronised edge is registered.
- R11: After reset, `dac_code_o` is 0, `frame_done_o` is 0 and `if_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| frm_n_i | input | 1 | Active-low frame strobe and chip enable |
| load_n_i | input | 1 | Active-low transfer strobe from the input latch to the DAC register |
| dac_code_o | output | 8 | DAC register contents |
| frame_done_o | output | 1 | One-cycle pulse when a full frame closes |
| if_en_o | output | 1 | Serial input buffers powered while high |

## Verification
The bench targets the following corner cases, and for each it names what a wrong design would do:
- A short frame followed by a load strobe. A design that latched partial words would put a corrupted code on the output.
- A long frame with extra clock edges. A counter that does not saturate would keep the last eight bits instead of the first eight.
- An aborted frame followed at once by a full one. Without a count restart on the frame edge, the two frames' bits would mix.
- Clock bursts while the frame strobe is high. These catch a shifter that is not gated by the enable.
- A load pulse with no word waiting, and a load held low through a frame. These separate a level-driven transfer from one tied to the pending word.
A cycle-level model also checks the latency of the enable and the single-cycle width of the completion pulse.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int unsigned WORD_W      = 8;
  parameter int unsigned SYNC_STAGES = 2;
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1);
  localparam int unsigned PIN_N      = 4;
  // pin lane positions inside the synchroniser bundle
  localparam int unsigned LANE_LOAD  = 0;
  localparam int unsigned LANE_DAT   = 1;
  localparam int unsigned LANE_CLK   = 2;
  localparam int unsigned LANE_FRM   = 3;
  // idle levels: frame high, clock high, data low, load high
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1101;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              frm_n_s,
  output logic [WORD_W-1:0] word_o,
  output logic              active_o,
  output logic              done_o
);
  logic              prev_frm_q, prev_clk_q;
  logic              act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic              frm_fall, frm_rise, clk_fall, full;

  assign frm_fall = prev_frm_q & ~frm_n_s;
  assign frm_rise = ~prev_frm_q & frm_n_s;
  assign clk_fall = prev_clk_q & ~sclk_s;
  assign full     = (cnt_q == CNT_W'(WORD_W));

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (frm_fall) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && frm_rise) begin
      act_d  = 1'b0;
      done_d = full;
    end else if (act_q && !frm_n_s && clk_fall && !full) begin
      sh_d  = {sh_q[WORD_W-2:0], sdat_s};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_frm_q <= 1'b1;
      prev_clk_q <= 1'b1;
      act_q      <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      prev_frm_q <= frm_n_s;
      prev_clk_q <= sclk_s;
      act_q      <= act_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      done_q     <= done_d;
    end
  end

  assign word_o   = sh_q;
  assign active_o = act_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sdac_loader.sv
module sdac_loader
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_n_s,
  output logic [WORD_W-1:0] dac_o
);
  logic [WORD_W-1:0] lat_q, lat_d;
  logic [WORD_W-1:0] dac_q, dac_d;
  logic              pend_q, pend_d;
  logic              lat_en, dac_en;

  always_comb begin
    lat_en = done_i;
    lat_d  = word_i;
    dac_en = 1'b0;
    dac_d  = lat_q;
    pend_d = pend_q;
    if (done_i) begin
      if (!load_n_s) begin
        dac_en = 1'b1;
        dac_d  = word_i;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end else if (pend_q && !load_n_s) begin
      dac_en = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      if (dac_en) dac_q <= dac_d;
      pend_q <= pend_d;
    end
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              frm_n_i,
  input  logic              load_n_i,
  output logic [WORD_W-1:0] dac_code_o,
  output logic              frame_done_o,
  output logic              if_en_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_N-1:0] pins_raw, pins_s;
  logic [WORD_W-1:0] word;
  logic             done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    pins_raw            = '0;
    pins_raw[LANE_LOAD] = load_n_i;
    pins_raw[LANE_DAT]  = ser_dat_i;
    pins_raw[LANE_CLK]  = ser_clk_i;
    pins_raw[LANE_FRM]  = frm_n_i;
  end

  sdac_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sdac_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sclk_s   (pins_s[LANE_CLK]),
    .sdat_s   (pins_s[LANE_DAT]),
    .frm_n_s  (pins_s[LANE_FRM]),
    .word_o   (word),
    .active_o (if_en_o),
    .done_o   (done)
  );

  sdac_loader u_load (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .done_i   (done),
    .word_i   (word),
    .load_n_s (pins_s[LANE_LOAD]),
    .dac_o    (dac_code_o)
  );

  assign frame_done_o = done;
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frm_n_i,
  input logic              load_n_i,
  input logic [WORD_W-1:0] dac_code_o,
  input logic              frame_done_o,
  input logic              if_en_o
);
  // R9: completion pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  // R9: pulse appears exactly as an open frame closes
  p_done_on_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!if_en_o && $past(if_en_o)));

  // R10: enable rises only after the frame pin was low two samples back
  p_en_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_en_o) |-> !$past(frm_n_i, 2));

  // R10: enable falls only after the frame pin was high two samples back
  p_en_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_en_o) |-> $past(frm_n_i, 2));

  // R5: DAC register moves only when the load pin was low
  p_dac_needs_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> !$past(load_n_i, 2));
endmodule

bind sdac_front sdac_front_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frm_n_i      (frm_n_i),
  .load_n_i     (load_n_i),
  .dac_code_o   (dac_code_o),
  .frame_done_o (frame_done_o),
  .if_en_o      (if_en_o)
);

// File: tb/test_sdac_front.sv
`timescale 1ns/1ps
module test_sdac_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1;
  logic       sdat = 1'b0;
  logic       frm_n = 1'b1;
  logic       ld_n = 1'b1;
  logic [7:0] dac;
  logic       done;
  logic       en;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdac_front i_sdac_front (
    .clk (clk), .rst_n (rst_n), .ser_clk_i (sclk), .ser_dat_i (sdat),
    .frm_n_i (frm_n), .load_n_i (ld_n), .dac_code_o (dac),
    .frame_done_o (done), .if_en_o (en)
  );

  // ---------------- behavioural reference ----------------
  // pin history: index 0 newest, two samples delay then one more for edge
  bit   hist_frm[$], hist_clk[$], hist_dat[$], hist_ld[$];
  bit   m_act, m_done, m_pend;
  int   m_cnt;
  logic [7:0] m_sh, m_lat, m_dac;
  int   rel_wait;

  task automatic model_reset();
    hist_frm = '{1, 1, 1}; hist_clk = '{1, 1, 1};
    hist_dat = '{0, 0, 0}; hist_ld  = '{1, 1, 1};
    m_act = 0; m_done = 0; m_pend = 0; m_cnt = 0;
    m_sh = 0; m_lat = 0; m_dac = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      rel_wait = 2;
    end else if (rel_wait > 0) begin
      rel_wait--;
    end else begin
      bit s_frm, p_frm, s_clk, p_clk, s_dat, s_ld;
      bit n_act, n_done;
      int n_cnt;
      logic [7:0] n_sh;
      s_frm = hist_frm[1]; p_frm = hist_frm[2];
      s_clk = hist_clk[1]; p_clk = hist_clk[2];
      s_dat = hist_dat[1]; s_ld = hist_ld[1];
      n_act = m_act; n_cnt = m_cnt; n_sh = m_sh; n_done = 0;
      if (p_frm && !s_frm) begin
        n_act = 1; n_cnt = 0;
      end else if (m_act && !p_frm && s_frm) begin
        n_act = 0; n_done = (m_cnt >= 8);
      end else if (m_act && !s_frm && p_clk && !s_clk && m_cnt < 8) begin
        n_sh = {m_sh[6:0], s_dat}; n_cnt = m_cnt + 1;
      end
      if (m_done) begin
        m_lat = m_sh;
        if (!s_ld) begin m_dac = m_sh; m_pend = 0; end
        else m_pend = 1;
      end else if (m_pend && !s_ld) begin
        m_dac = m_lat; m_pend = 0;
      end
      m_act = n_act; m_cnt = n_cnt; m_sh = n_sh; m_done = n_done;
      void'(hist_frm.pop_back()); hist_frm.push_front(frm_n);
      void'(hist_clk.pop_back()); hist_clk.push_front(sclk);
      void'(hist_dat.pop_back()); hist_dat.push_front(sdat);
      void'(hist_ld.pop_back());  hist_ld.push_front(ld_n);
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R1/R5/R6 dac model", dac, m_dac);
      check_val("R9 done model", done, m_done);
      check_val("R10 enable model", en, m_act);
      if (done) pulses++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the low n bits of v, highest first; data changes on the rising edge
  task automatic send_frame(input logic [15:0] v, input int n);
    frm_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
    sclk = 1'b1;
    wait_clk(4);
    frm_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic pulse_load();
    ld_n = 1'b0;
    wait_clk(4);
    ld_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    int p0;
    model_reset();
    wait_clk(3);
    // R11: reset state
    check_val("R11 dac reset", dac, 0);
    check_val("R11 done reset", done, 0);
    check_val("R11 enable reset", en, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check_val("R11 enable after release", en, 0);

    // R10: enable latency on a frame edge
    frm_n = 1'b0;
    wait_clk(2);
    check_val("R10 enable not yet", en, 0);
    wait_clk(1);
    check_val("R10 enable after three clocks", en, 1);
    frm_n = 1'b1;
    wait_clk(2);
    check_val("R10 enable still on", en, 1);
    wait_clk(1);
    check_val("R10 enable off after three clocks", en, 0);
    wait_clk(6);

    // R5: held word does not reach the DAC while load is high
    p0 = pulses;
    send_frame(16'h00A5, 8);
    check_val("R9 one pulse per full frame", pulses - p0, 1);
    check_val("R5 dac waits for load", dac, 8'h00);
    pulse_load();
    check_val("R1 R2 msb-first word", dac, 8'hA5);
    pulse_load();
    check_val("R5 load with nothing waiting", dac, 8'hA5);

    // R3: clock activity while the frame pin is high
    p0 = pulses;
    sdat = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
    sdat = 1'b0;
    check_val("R3 no pulse while deselected", pulses - p0, 0);
    pulse_load();
    check_val("R3 dac untouched", dac, 8'hA5);

    // R7: short frame discarded, held word survives
    send_frame(16'h003C, 8);
    p0 = pulses;
    send_frame(16'h0007, 3);
    check_val("R7 no pulse on short frame", pulses - p0, 0);
    check_val("R7 dac unchanged", dac, 8'hA5);
    pulse_load();
    check_val("R7 latch kept earlier word", dac, 8'h3C);

    // R6: load held low updates on completion
    ld_n = 1'b0;
    wait_clk(4);
    send_frame(16'h005A, 8);
    check_val("R6 automatic update", dac, 8'h5A);

    // R8: extra clock edges ignored
    send_frame(16'h096F, 12);
    check_val("R8 first eight bits kept", dac, 8'h96);

    // R4: aborted frame then full frame, count restarts
    send_frame(16'h0005, 3);
    check_val("R4 abort leaves dac", dac, 8'h96);
    send_frame(16'h00C3, 8);
    check_val("R4 new frame only", dac, 8'hC3);

    // R2: constant data with alternating words
    send_frame(16'h0000, 8);
    check_val("R2 all zero word", dac, 8'h00);
    send_frame(16'h00FF, 8);
    check_val("R2 all one word", dac, 8'hFF);
    ld_n = 1'b1;
    wait_clk(6);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule